// File: doc/BRIEF.md
# SHA-224/256 Compression Engine

This block compresses one already padded 512-bit message block per command into a set of eight 32-bit chaining words, using the SHA-2 compression function. It performs one round per clock. A 16-word sliding window expands the message schedule, and a 64-entry constant table feeds the rounds. After the last round, the working variables are added into the chaining words. Padding and length encoding stay with the caller.

A hash begins with a start pulse on `init_i`, which seeds the chaining words from the initial values of the selected variant: `mode256_i` = 1 selects SHA-256 and 0 selects SHA-224. Each later block of the same message is applied with `next_i`, which continues from the current chaining words. To resume a suspended hash, the caller writes the saved chaining words through `load_state_i` with the `load_i` strobe while the engine is idle, and then issues `next_i`.

Top module: `sha2_compress_core`

## Requirements
- R1: After a synchronous reset, `ready_o` is 1, `digest_valid_o` is 0, `digest_o` is all zero, and the variant register selects SHA-256.
- R2: An accepted `init_i` with `mode256_i`=1 hashes from the SHA-256 initial values. The padded block "abc" (0x61626380, zeros, final word 0x18) yields BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD.
- R3: With `mode256_i`=0 the SHA-224 initial values are used. For the same block, `digest_o[255:32]` is 23097D22 3405D822 8642A477 BDA255B3 2AADBCE4 BDA0B3F7 E36C9DA7, and `digest_o[31:0]` reads 0 because that word is not part of the result.
- R4: An accepted `next_i` continues from the current chaining words, so a two-block message gives the correct digest after both blocks in either variant.
- R5: `ready_o` falls on the clock edge that accepts a start and rises again 65 edges later (64 rounds plus the final addition). `digest_valid_o` rises on that same edge.
- R6: While the engine is busy, `digest_valid_o` is 0 and `digest_o` holds the chaining words the run started from.
- R7: A `load_i` strobe accepted while the engine is idle replaces all eight chaining words with `load_state_i` (word 0 in bits [255:224]) and clears `digest_valid_o`.
- R8: After loading 85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A, a `next_i` in SHA-256 mode on a block that is zero except for a final word 0x1C0 yields 248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1.
- R9: While the engine is busy, `init_i`, `next_i`, `load_i` and changes to `block_i` or `mode256_i` have no effect on the run or its result.
- R10: In a single idle cycle, `init_i` takes priority over `next_i`, and a start takes priority over `load_i`.
- R11: The block is consumed big-endian: schedule word 0 is `block_i[511:480]`, and digest word 0 is `digest_o[255:224]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Start a new hash from the variant's initial values |
| next_i | input | 1 | Compress a further block onto the current chaining words |
| mode256_i | input | 1 | 1 = SHA-256, 0 = SHA-224, sampled at a start |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| load_i | input | 1 | Strobe to overwrite the chaining words while idle |
| load_state_i | input | 256 | Chaining words to load, word 0 in the top bits |
| ready_o | output | 1 | Engine idle and able to accept a command |
| digest_valid_o | output | 1 | `digest_o` holds the result of a completed block |
| digest_o | output | 256 | Chaining words (lowest word zeroed in SHA-224 mode) |

## Verification
The engine is run on several inputs. The single "abc" block is applied in both variants, which separates the two initial-value sets and the masking of the lowest word. A two-block message in both variants exercises chaining through `next_i`, and a loaded intermediate state followed by a final block exercises resumption. Each digest is checked against a behavioural SHA-2 model in the bench that derives its round constants from cube roots of primes, and also against the published values. Cycle-by-cycle comparison of `ready_o`, `digest_valid_o` and `digest_o` exposes timing errors, commands that are wrongly accepted while busy, and the wrong winner when `init_i`, `next_i` and `load_i` collide.

// File: rtl/sha2_pkg.sv
`timescale 1ns/1ps
package sha2_pkg;

  localparam int WORD_W  = 32;
  localparam int N_WORDS = 8;
  localparam int WIN     = 16;
  localparam int ROUNDS  = 64;
  localparam int STATE_W = WORD_W * N_WORDS;
  localparam int BLOCK_W = WORD_W * WIN;
  localparam int RND_W   = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ROUND = 2'd1,
    PH_FINAL = 2'd2
  } phase_e;

  localparam logic [STATE_W-1:0] IV_256 = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [STATE_W-1:0] IV_224 = {
    32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
    32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

endpackage

// File: rtl/sha2_kconst.sv
`timescale 1ns/1ps
module sha2_kconst
  import sha2_pkg::*;
(
  input  logic [RND_W-1:0] idx_i,
  output word_t            k_o
);

  localparam word_t KTAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  // Asynchronous ROM read; a tool may place it in LUTs or distributed RAM.
  assign k_o = KTAB[idx_i];

endmodule

// File: rtl/sha2_msg_sched.sv
`timescale 1ns/1ps
module sha2_msg_sched
  import sha2_pkg::*;
(
  input  logic               clk,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [BLOCK_W-1:0] block_i,
  output word_t              w_o
);

  // Window slot j holds schedule word t+j while round t is executing.
  localparam int TAP_S1 = WIN - 2;
  localparam int TAP_W7 = WIN - 7;
  localparam int TAP_S0 = 1;

  word_t win_q [WIN];
  word_t expand;

  assign expand = sml_sig1(win_q[TAP_S1]) + win_q[TAP_W7]
                + sml_sig0(win_q[TAP_S0]) + win_q[0];

  always_ff @(posedge clk) begin
    if (load_i) begin
      for (int i = 0; i < WIN; i++)
        win_q[i] <= block_i[BLOCK_W-1-WORD_W*i -: WORD_W];
    end else if (shift_i) begin
      for (int i = 0; i < WIN-1; i++)
        win_q[i] <= win_q[i+1];
      win_q[WIN-1] <= expand;
    end
  end

  assign w_o = win_q[0];

endmodule

// File: rtl/sha2_round_fn.sv
`timescale 1ns/1ps
module sha2_round_fn
  import sha2_pkg::*;
(
  input  logic [STATE_W-1:0] st_i,
  input  word_t              k_i,
  input  word_t              w_i,
  output logic [STATE_W-1:0] st_o
);

  word_t va, vb, vc, vd, ve, vf, vg, vh;
  word_t t1, t2;

  assign {va, vb, vc, vd, ve, vf, vg, vh} = st_i;

  assign t1 = vh + big_sig1(ve) + ((ve & vf) ^ (~ve & vg)) + k_i + w_i;
  assign t2 = big_sig0(va) + ((va & vb) ^ (va & vc) ^ (vb & vc));

  assign st_o = {t1 + t2, va, vb, vc, vd + t1, ve, vf, vg};

endmodule

// File: rtl/sha2_compress_core.sv
`timescale 1ns/1ps
module sha2_compress_core
  import sha2_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               init_i,
  input  logic               next_i,
  input  logic               mode256_i,
  input  logic [BLOCK_W-1:0] block_i,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_state_i,
  output logic               ready_o,
  output logic               digest_valid_o,
  output logic [STATE_W-1:0] digest_o
);

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  phase_e             phase_q;
  logic [RND_W-1:0]   round_q;
  logic               ready_q, valid_q, mode_q;
  logic [STATE_W-1:0] chain_q, work_q;
  logic [STATE_W-1:0] seed, round_out, chain_sum;
  logic               start, in_round;
  word_t              k_cur, w_cur;

  assign start    = ready_q & (init_i | next_i);
  assign in_round = (phase_q == PH_ROUND);
  assign seed     = init_i ? (mode256_i ? IV_256 : IV_224) : chain_q;

  sha2_kconst u_kconst (
    .idx_i (round_q),
    .k_o   (k_cur)
  );

  sha2_msg_sched u_sched (
    .clk     (clk),
    .load_i  (start),
    .shift_i (in_round),
    .block_i (block_i),
    .w_o     (w_cur)
  );

  sha2_round_fn u_round (
    .st_i (work_q),
    .k_i  (k_cur),
    .w_i  (w_cur),
    .st_o (round_out)
  );

  // Eight independent 32-bit adders for the final chaining step.
  for (genvar i = 0; i < N_WORDS; i++) begin : g_fold
    assign chain_sum[STATE_W-1-WORD_W*i -: WORD_W] =
      chain_q[STATE_W-1-WORD_W*i -: WORD_W] + work_q[STATE_W-1-WORD_W*i -: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      round_q <= '0;
      ready_q <= 1'b1;
      valid_q <= 1'b0;
      mode_q  <= 1'b1;
      chain_q <= '0;
      work_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            chain_q <= seed;
            work_q  <= seed;
            mode_q  <= mode256_i;
            round_q <= '0;
            ready_q <= 1'b0;
            valid_q <= 1'b0;
            phase_q <= PH_ROUND;
          end else if (load_i) begin
            chain_q <= load_state_i;
            valid_q <= 1'b0;
          end
        end
        PH_ROUND: begin
          work_q  <= round_out;
          round_q <= round_q + 1'b1;
          if (round_q == LAST_RND) phase_q <= PH_FINAL;
        end
        PH_FINAL: begin
          chain_q <= chain_sum;
          ready_q <= 1'b1;
          valid_q <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ready_o        = ready_q;
  assign digest_valid_o = valid_q;
  assign digest_o       = {chain_q[STATE_W-1:WORD_W], mode_q ? chain_q[WORD_W-1:0] : '0};

endmodule

// File: rtl/sha2_compress_chk.sv
`timescale 1ns/1ps
module sha2_compress_chk
  import sha2_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               init_i,
  input logic               next_i,
  input logic               load_i,
  input logic               ready_o,
  input logic               digest_valid_o,
  input logic [STATE_W-1:0] digest_o,
  input logic [RND_W-1:0]   round_q,
  input logic               in_round
);

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  a_r5_start_drops_ready: assert property (@(posedge clk) disable iff (rst)
    ready_o && (init_i || next_i) |=> !ready_o);

  a_r5_valid_with_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> digest_valid_o);

  a_r5_valid_rise_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(digest_valid_o) |-> $rose(ready_o));

  a_r5_round_steps: assert property (@(posedge clk) disable iff (rst)
    in_round && (round_q != LAST_RND) |=> in_round && (round_q == $past(round_q) + 1'b1));

  a_r6_valid_low_busy: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> !digest_valid_o);

  a_r6_digest_stable_busy: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> (ready_o || $stable(digest_o)));

  a_r7_load_clears_valid: assert property (@(posedge clk) disable iff (rst)
    ready_o && load_i && !init_i && !next_i |=> ready_o && !digest_valid_o);

endmodule

bind sha2_compress_core sha2_compress_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .init_i         (init_i),
  .next_i         (next_i),
  .load_i         (load_i),
  .ready_o        (ready_o),
  .digest_valid_o (digest_valid_o),
  .digest_o       (digest_o),
  .round_q        (round_q),
  .in_round       (in_round)
);

// File: tb/sha2_compress_core_tb_top.sv
`timescale 1ns/1ps
module sha2_compress_core_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_i = 1'b0, next_i = 1'b0, mode256_i = 1'b1, load_i = 1'b0;
  logic [511:0] block_i = '0;
  logic [255:0] load_state_i = '0;
  logic         ready_o, digest_valid_o;
  logic [255:0] digest_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit monitor_on = 0;

  always #10 clk = ~clk;

  sha2_compress_core dut_i (
    .clk, .rst, .init_i, .next_i, .mode256_i, .block_i,
    .load_i, .load_state_i, .ready_o, .digest_valid_o, .digest_o
  );

  // ---------------- reference SHA-2 arithmetic ----------------
  logic [31:0] kref [64];
  logic [31:0] ivref256 [8];
  logic [31:0] ivref224 [8] = '{32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                                32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_compress(input logic [255:0] h, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] s0, s1, t1, t2;
    logic [255:0] res;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++) begin
      s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
      s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
      w[t] = w[t-16] + s0 + w[t-7] + s1;
    end
    for (int i = 0; i < 8; i++) v[i] = h[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kref[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[255-32*i -: 32] = h[255-32*i -: 32] + v[i];
    return res;
  endfunction

  function automatic logic [255:0] iv_of(input bit m256);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = m256 ? ivref256[i] : ivref224[i];
    return r;
  endfunction

  initial begin
    int p, n;
    bit prime;
    real c;
    p = 2; n = 0;
    while (n < 64) begin
      prime = 1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) prime = 0;
      if (prime) begin
        c = $pow(real'(p), 1.0 / 3.0);
        kref[n] = 32'(longint'($floor((c - $floor(c)) * 4294967296.0)));
        if (n < 8) begin
          c = $sqrt(real'(p));
          ivref256[n] = 32'(longint'($floor((c - $floor(c)) * 4294967296.0)));
        end
        n++;
      end
      p++;
    end
  end

  // ---------------- cycle-level behavioural model ----------------
  bit           m_ready = 1, m_valid = 0, m_mode = 1;
  logic [255:0] m_chain = '0, m_pending = '0;
  int           m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ready = 1; m_valid = 0; m_mode = 1; m_chain = '0; m_cnt = 0;
    end else if (!m_ready) begin
      m_cnt++;
      if (m_cnt == 65) begin
        m_ready = 1; m_valid = 1; m_chain = m_pending;
      end
    end else if (init_i || next_i) begin
      m_chain   = init_i ? iv_of(mode256_i) : m_chain;
      m_pending = ref_compress(m_chain, block_i);
      m_mode    = mode256_i;
      m_ready   = 0; m_valid = 0; m_cnt = 0;
    end else if (load_i) begin
      m_chain = load_state_i; m_valid = 0;
    end
  end

  function automatic logic [255:0] shown(input logic [255:0] ch, input bit m256);
    return {ch[255:32], m256 ? ch[31:0] : 32'h0};
  endfunction

  // Compared on every falling edge (R5, R6, R9 timing and visibility).
  always @(negedge clk) begin
    if (monitor_on && !rst) begin
      tests++;
      if (ready_o !== m_ready || digest_valid_o !== m_valid ||
          digest_o !== shown(m_chain, m_mode)) begin
        fails++;
        $display("FAIL R5/R6/R9 cycle compare: got rdy=%0b vld=%0b dig=%h exp rdy=%0b vld=%0b dig=%h",
                 ready_o, digest_valid_o, digest_o, m_ready, m_valid, shown(m_chain, m_mode));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic start_run(input bit is_init, input bit m256, input logic [511:0] blk);
    @(negedge clk);
    block_i = blk; mode256_i = m256; init_i = is_init; next_i = !is_init;
    @(negedge clk);
    init_i = 0; next_i = 0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!ready_o) begin
      @(negedge clk);
      n++;
    end
  endtask

  localparam logic [511:0] BLK_ABC = {32'h61626380, 416'h0, 64'h18};
  localparam logic [511:0] BLK_2A  = 512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
  localparam logic [511:0] BLK_2B  = {480'h0, 32'h1C0};
  localparam logic [255:0] D_ABC256 = 256'hBA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD;
  localparam logic [223:0] D_ABC224 = 224'h23097D223405D8228642A477BDA255B32AADBCE4BDA0B3F7E36C9DA7;
  localparam logic [223:0] D_2A224  = 224'h8250e65dbcf62f8466659c3333e5e91a10c8b7b0953927691f1419c2;
  localparam logic [223:0] D_2B224  = 224'h75388b16512776cc5dba5da1fd890150b0c6455cb4f58b1952522525;
  localparam logic [255:0] D_2A256  = 256'h85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A;
  localparam logic [255:0] D_2B256  = 256'h248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1;

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    monitor_on = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset flags", {254'h0, ready_o, digest_valid_o}, {254'h0, 2'b10});
    chk("R1 reset digest", digest_o, '0);

    // R3: single block, SHA-224
    start_run(1, 0, BLK_ABC); wait_done(n);
    chk("R3 abc224 upper words", {32'h0, digest_o[255:32]}, {32'h0, D_ABC224});
    chk("R3 abc224 low word zero", {224'h0, digest_o[31:0]}, '0);
    chk("R3 reference model", digest_o, shown(ref_compress(iv_of(0), BLK_ABC), 0));

    // R4: two-block chaining, SHA-224
    start_run(1, 0, BLK_2A); wait_done(n);
    chk("R4 224 first block", {32'h0, digest_o[255:32]}, {32'h0, D_2A224});
    start_run(0, 0, BLK_2B); wait_done(n);
    chk("R4 224 second block", {32'h0, digest_o[255:32]}, {32'h0, D_2B224});

    // R2, R11, R5: single block, SHA-256, with latency
    start_run(1, 1, BLK_ABC); wait_done(n);
    chk("R5 latency edges", 256'(n), 256'd65);
    chk("R5 valid at done", {255'h0, digest_valid_o}, 256'd1);
    chk("R2 R11 abc256", digest_o, D_ABC256);

    // R4: two-block chaining, SHA-256
    start_run(1, 1, BLK_2A); wait_done(n);
    chk("R4 256 first block", digest_o, D_2A256);
    start_run(0, 1, BLK_2B); wait_done(n);
    chk("R4 256 second block", digest_o, D_2B256);

    // R7, R8: load a state, then resume
    @(negedge clk); load_i = 1; load_state_i = D_2A256;
    @(negedge clk); load_i = 0;
    chk("R7 load clears valid", {255'h0, digest_valid_o}, '0);
    chk("R7 loaded words visible", digest_o, D_2A256);
    start_run(0, 1, BLK_2B); wait_done(n);
    chk("R8 resume digest", digest_o, D_2B256);

    // R9: commands and input changes during a run are ignored
    start_run(1, 1, BLK_ABC);
    repeat (10) @(negedge clk);
    init_i = 1; next_i = 1; load_i = 1; mode256_i = 0; block_i = BLK_2A; load_state_i = '1;
    @(negedge clk);
    init_i = 0; next_i = 0; load_i = 0;
    repeat (5) @(negedge clk);
    chk("R9 busy digest unchanged", digest_o, iv_of(1));
    wait_done(n);
    chk("R9 busy commands ignored", digest_o, D_ABC256);
    chk("R9 run length unchanged", 256'(n), 256'd49);

    // R10: init beats next, start beats load
    @(negedge clk);
    init_i = 1; next_i = 1; load_i = 1; mode256_i = 1; block_i = BLK_ABC; load_state_i = '1;
    @(negedge clk);
    init_i = 0; next_i = 0; load_i = 0;
    wait_done(n);
    chk("R10 init and start priority", digest_o, D_ABC256);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R5 watchdog: got no completion exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule